// File: doc/BRIEF.md
# Dual-Clock Almost-Flag Generator

This block tracks the fill level of two opposite-direction FIFO channels that join two independently clocked ports, A and B, and drives the active-low almost-empty and almost-full flags for both. Channel 1 is filled from port A and drained from port B. Channel 2 is filled from port B and drained from port A. It holds no data. It counts the qualified operations on each port, exchanges Gray-coded pointers between the two clock domains, and registers each flag in the domain of the port that watches it.

Each port presents an enable, an active-low select and a direction bit. A qualified operation counts on the rising edge of that port's clock. The programmable offsets X (empty side) and Y (full side) are captured in each domain while that domain is in reset. Later changes to them have no effect until the next reset. DEPTH must be a power of two, and both offsets must be less than DEPTH.

Top module: `bidi_almost_flags`

## Requirements
- R1: An operation counts only at a rising edge of its port's clock where enable is 1 and select_n is 0. On port A, wr_a=1 fills channel 1 and wr_a=0 drains channel 2. On port B, wr_b=1 fills channel 2 and wr_b=0 drains channel 1. Any other combination leaves every count unchanged.
- R2: An almost-empty flag is 0 while its channel holds X words or fewer, and 1 once it holds X+1 or more.
- R3: An almost-full flag is 0 while its channel holds DEPTH-Y words or more, and 1 while it holds DEPTH-Y-1 or fewer.
- R4: An operation on the port that owns a flag is reflected in that flag immediately after the same clock edge that counted the operation.
- R5: An operation on the far port changes the flag at the second edge of the flag's clock after the far edge, or at the third edge when the two edges are close. It never changes the flag at the first edge.
- R6: During reset and right after it, almost-full flags are 1 and almost-empty flags are 0. Offsets are taken from x_ofs/y_ofs while reset is active, and changes made after reset are ignored.
- R7: A fill of a channel that its filling side sees as full is discarded. A drain of a channel that its draining side sees as empty is discarded.
- R8: An almost-full flag can fall only after a fill on its own port. An almost-empty flag can fall only after a drain on its own port. Far-port operations only ever raise flags.
- R9: Channel 2 behaves like channel 1 with the roles of the ports swapped: its almost-full flag is on clock B and its almost-empty flag is on clock A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset; released separately into each domain |
| en_a | input | 1 | Port A operation enable |
| cs_a_n | input | 1 | Port A select, active low |
| wr_a | input | 1 | Port A direction: 1 fills channel 1, 0 drains channel 2 |
| en_b | input | 1 | Port B operation enable |
| cs_b_n | input | 1 | Port B select, active low |
| wr_b | input | 1 | Port B direction: 1 fills channel 2, 0 drains channel 1 |
| x_ofs | input | $clog2(DEPTH) | Almost-empty offset X, captured during reset |
| y_ofs | input | $clog2(DEPTH) | Almost-full offset Y, captured during reset |
| a_afull_n | output | 1 | Channel 1 almost-full, clock A |
| a_aempty_n | output | 1 | Channel 2 almost-empty, clock A |
| b_afull_n | output | 1 | Channel 2 almost-full, clock B |
| b_aempty_n | output | 1 | Channel 1 almost-empty, clock B |

## Verification
A flag owned by the operating port is due right after the edge that counted the operation. The bench drives each operation on one falling edge and checks that flag on the next falling edge of the same clock. A far-port operation is due two flag-clock edges later, or three when the edges are close. The bench therefore checks the old value at the first falling edge of the flag clock after the operation and the new value at the third, so either legal edge passes. Checks that do not target crossing latency first wait four cycles of the observing clock so that the pointers have settled.

// File: rtl/almflag_pkg.sv
package almflag_pkg;

  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_FILL  = 2'd1,
    PORT_DRAIN = 2'd2
  } port_op_e;

  // A port acts only when enabled and selected; direction picks the channel role.
  function automatic port_op_e port_decode(input logic en, input logic sel_n, input logic dir);
    if (!en || sel_n) return PORT_IDLE;
    return dir ? PORT_FILL : PORT_DRAIN;
  endfunction

endpackage

// File: rtl/almflag_sync.sv
module almflag_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_last,
  output logic [W-1:0] q_prev
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q_last = chain[STAGES-1];
  assign q_prev = chain[STAGES-2];

endmodule

// File: rtl/almflag_rst_sync.sv
module almflag_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic dom_rst_n,
  output logic cfg_load
);

  logic [1:0] shift_q;
  logic       load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= 2'b00;
      load_q  <= 1'b1;
    end else begin
      shift_q <= {shift_q[0], 1'b1};
      load_q  <= !shift_q[0];
    end
  end

  assign dom_rst_n = shift_q[1];
  assign cfg_load  = load_q;

endmodule

// File: rtl/almflag_side.sv
module almflag_side #(
  parameter int DEPTH       = 16,
  parameter bit FILL_SIDE   = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_load,
  input  logic                       step_req,
  input  logic [$clog2(DEPTH)-1:0]   ofs_in,
  input  logic [$clog2(DEPTH):0]     far_gray,
  output logic [$clog2(DEPTH):0]     own_gray,
  output logic                       flag_n
);

  localparam int PW = $clog2(DEPTH) + 1;
  localparam int OW = $clog2(DEPTH);
  localparam logic [PW-1:0] DEPTH_P  = PW'(DEPTH);
  localparam logic          FLAG_RST = FILL_SIDE;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [OW-1:0] ofs_q;
  logic [PW-1:0] own_bin, own_bin_nxt;
  logic [PW-1:0] sync_last, sync_prev;
  logic [PW-1:0] far_now, far_nxt;
  logic [PW-1:0] count_now, count_nxt;
  logic          step_ok, flag_nxt;

  almflag_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      (far_gray),
    .q_last (sync_last),
    .q_prev (sync_prev)
  );

  // far_nxt is what the last stage will hold after this edge
  assign far_now = from_gray(sync_last);
  assign far_nxt = from_gray(sync_prev);

  if (FILL_SIDE) begin : g_fill
    always_comb begin
      count_now   = own_bin - far_now;
      step_ok     = step_req && (count_now != DEPTH_P);
      own_bin_nxt = own_bin + PW'(step_ok);
      count_nxt   = own_bin_nxt - far_nxt;
      flag_nxt    = !(count_nxt >= (DEPTH_P - PW'(ofs_q)));
    end
  end else begin : g_drain
    always_comb begin
      count_now   = far_now - own_bin;
      step_ok     = step_req && (count_now != '0);
      own_bin_nxt = own_bin + PW'(step_ok);
      count_nxt   = far_nxt - own_bin_nxt;
      flag_nxt    = count_nxt > PW'(ofs_q);
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_load) ofs_q <= ofs_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_bin  <= '0;
      own_gray <= '0;
      flag_n   <= FLAG_RST;
    end else begin
      own_bin  <= own_bin_nxt;
      own_gray <= to_gray(own_bin_nxt);
      flag_n   <= flag_nxt;
    end
  end

endmodule

// File: rtl/bidi_almost_flags.sv
module bidi_almost_flags
  import almflag_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_a,
  input  logic                     clk_b,
  input  logic                     rst_n,
  input  logic                     en_a,
  input  logic                     cs_a_n,
  input  logic                     wr_a,
  input  logic                     en_b,
  input  logic                     cs_b_n,
  input  logic                     wr_b,
  input  logic [$clog2(DEPTH)-1:0] x_ofs,
  input  logic [$clog2(DEPTH)-1:0] y_ofs,
  output logic                     a_afull_n,
  output logic                     a_aempty_n,
  output logic                     b_afull_n,
  output logic                     b_aempty_n
);

  localparam int PW = $clog2(DEPTH) + 1;
  localparam int NCH = 2;

  logic     a_rst_n, a_load, b_rst_n, b_load;
  port_op_e op_a, op_b;

  almflag_rst_sync u_rst_a (.clk(clk_a), .rst_n(rst_n), .dom_rst_n(a_rst_n), .cfg_load(a_load));
  almflag_rst_sync u_rst_b (.clk(clk_b), .rst_n(rst_n), .dom_rst_n(b_rst_n), .cfg_load(b_load));

  assign op_a = port_decode(en_a, cs_a_n, wr_a);
  assign op_b = port_decode(en_b, cs_b_n, wr_b);

  // index 0: channel 1 (A fills, B drains); index 1: channel 2 (B fills, A drains)
  logic [NCH-1:0] w_clk, r_clk, w_rst, r_rst, w_load, r_load;
  logic [NCH-1:0] fill_req, drain_req, af_n, ae_n;
  logic [PW-1:0]  w_gray [NCH];
  logic [PW-1:0]  r_gray [NCH];

  assign w_clk     = {clk_b, clk_a};
  assign r_clk     = {clk_a, clk_b};
  assign w_rst     = {b_rst_n, a_rst_n};
  assign r_rst     = {a_rst_n, b_rst_n};
  assign w_load    = {b_load, a_load};
  assign r_load    = {a_load, b_load};
  assign fill_req  = {op_b == PORT_FILL,  op_a == PORT_FILL};
  assign drain_req = {op_a == PORT_DRAIN, op_b == PORT_DRAIN};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    almflag_side #(.DEPTH(DEPTH), .FILL_SIDE(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_fill (
      .clk      (w_clk[c]),
      .rst_n    (w_rst[c]),
      .cfg_load (w_load[c]),
      .step_req (fill_req[c]),
      .ofs_in   (y_ofs),
      .far_gray (r_gray[c]),
      .own_gray (w_gray[c]),
      .flag_n   (af_n[c])
    );
    almflag_side #(.DEPTH(DEPTH), .FILL_SIDE(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_drain (
      .clk      (r_clk[c]),
      .rst_n    (r_rst[c]),
      .cfg_load (r_load[c]),
      .step_req (drain_req[c]),
      .ofs_in   (x_ofs),
      .far_gray (w_gray[c]),
      .own_gray (r_gray[c]),
      .flag_n   (ae_n[c])
    );
  end

  assign a_afull_n  = af_n[0];
  assign b_afull_n  = af_n[1];
  assign b_aempty_n = ae_n[0];
  assign a_aempty_n = ae_n[1];

endmodule

// File: rtl/almflag_checker.sv
module almflag_checker (
  input logic clk_a,
  input logic clk_b,
  input logic rst_n,
  input logic a_rst_n,
  input logic b_rst_n,
  input logic en_a,
  input logic cs_a_n,
  input logic wr_a,
  input logic en_b,
  input logic cs_b_n,
  input logic wr_b,
  input logic a_afull_n,
  input logic a_aempty_n,
  input logic b_afull_n,
  input logic b_aempty_n
);

  logic a_put, a_take, b_put, b_take;
  assign a_put  = en_a && !cs_a_n &&  wr_a;
  assign a_take = en_a && !cs_a_n && !wr_a;
  assign b_put  = en_b && !cs_b_n &&  wr_b;
  assign b_take = en_b && !cs_b_n && !wr_b;

  AST_A_AF_OWN_FILL:  assert property (@(posedge clk_a) disable iff (!a_rst_n) $fell(a_afull_n)  |-> $past(a_put));  // R8
  AST_B_AF_OWN_FILL:  assert property (@(posedge clk_b) disable iff (!b_rst_n) $fell(b_afull_n)  |-> $past(b_put));  // R8
  AST_A_AE_OWN_DRAIN: assert property (@(posedge clk_a) disable iff (!a_rst_n) $fell(a_aempty_n) |-> $past(a_take)); // R8
  AST_B_AE_OWN_DRAIN: assert property (@(posedge clk_b) disable iff (!b_rst_n) $fell(b_aempty_n) |-> $past(b_take)); // R8
  AST_A_RESET_FLAGS:  assert property (@(posedge clk_a) disable iff (!rst_n) $rose(a_rst_n) |-> (a_afull_n && !a_aempty_n)); // R6
  AST_B_RESET_FLAGS:  assert property (@(posedge clk_b) disable iff (!rst_n) $rose(b_rst_n) |-> (b_afull_n && !b_aempty_n)); // R6

endmodule

bind bidi_almost_flags almflag_checker u_chk (
  .clk_a      (clk_a),
  .clk_b      (clk_b),
  .rst_n      (rst_n),
  .a_rst_n    (a_rst_n),
  .b_rst_n    (b_rst_n),
  .en_a       (en_a),
  .cs_a_n     (cs_a_n),
  .wr_a       (wr_a),
  .en_b       (en_b),
  .cs_b_n     (cs_b_n),
  .wr_b       (wr_b),
  .a_afull_n  (a_afull_n),
  .a_aempty_n (a_aempty_n),
  .b_afull_n  (b_afull_n),
  .b_aempty_n (b_aempty_n)
);

// File: tb/bidi_almost_flags_test.sv
module bidi_almost_flags_test;

  localparam int D  = 16;
  localparam int XC = 3;
  localparam int YC = 2;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n = 1'b0;
  logic en_a = 1'b0, cs_a_n = 1'b1, wr_a = 1'b0;
  logic en_b = 1'b0, cs_b_n = 1'b1, wr_b = 1'b0;
  logic [3:0] x_ofs = 4'(XC);
  logic [3:0] y_ofs = 4'(YC);
  logic a_afull_n, a_aempty_n, b_afull_n, b_aempty_n;

  int total = 0;
  int bad   = 0;

  always #4 clk_a = ~clk_a;
  initial begin
    #3 clk_b = 1'b1;
    forever #4 clk_b = ~clk_b;
  end

  bidi_almost_flags #(.DEPTH(D)) uut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .en_a(en_a), .cs_a_n(cs_a_n), .wr_a(wr_a),
    .en_b(en_b), .cs_b_n(cs_b_n), .wr_b(wr_b),
    .x_ofs(x_ofs), .y_ofs(y_ofs),
    .a_afull_n(a_afull_n), .a_aempty_n(a_aempty_n),
    .b_afull_n(b_afull_n), .b_aempty_n(b_aempty_n)
  );

  function automatic logic exp_ae(input int n);
    return n > XC;
  endfunction

  function automatic logic exp_af(input int n);
    return !(n >= D - YC);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic op_a(input logic dir, input logic en = 1'b1, input logic sel_n = 1'b0);
    @(negedge clk_a);
    en_a = en; cs_a_n = sel_n; wr_a = dir;
    @(negedge clk_a);
    en_a = 1'b0; cs_a_n = 1'b1; wr_a = 1'b0;
  endtask

  task automatic op_b(input logic dir, input logic en = 1'b1, input logic sel_n = 1'b0);
    @(negedge clk_b);
    en_b = en; cs_b_n = sel_n; wr_b = dir;
    @(negedge clk_b);
    en_b = 1'b0; cs_b_n = 1'b1; wr_b = 1'b0;
  endtask

  task automatic wait_a(input int n); repeat (n) @(negedge clk_a); endtask
  task automatic wait_b(input int n); repeat (n) @(negedge clk_b); endtask

  int n1 = 0;
  int n2 = 0;

  task automatic t_reset;
    rst_n = 1'b0;
    wait_a(6);
    check("R6 reset a_afull_n", a_afull_n, 1'b1);
    check("R6 reset a_aempty_n", a_aempty_n, 1'b0);
    check("R6 reset b_afull_n", b_afull_n, 1'b1);
    check("R6 reset b_aempty_n", b_aempty_n, 1'b0);
    rst_n = 1'b1;
    wait_a(5);
    check("R6 post-reset a_afull_n", a_afull_n, 1'b1);
    check("R6 post-reset a_aempty_n", a_aempty_n, 1'b0);
    check("R6 post-reset b_afull_n", b_afull_n, 1'b1);
    check("R6 post-reset b_aempty_n", b_aempty_n, 1'b0);
    x_ofs = 4'd0;  // must be ignored (R6)
    y_ofs = 4'd0;
  endtask

  task automatic t_empty_drain;
    for (int i = 0; i < 3; i++) op_b(1'b0);  // R7: channel 1 empty, discarded
    wait_b(2);
    check("R7 empty drain b_aempty_n", b_aempty_n, 1'b0);
  endtask

  task automatic t_qualify;
    for (int i = 0; i < 3; i++) begin op_a(1'b1); n1++; end
    wait_b(4);
    check("R2 ch1 at X b_aempty_n", b_aempty_n, 1'b0);
    for (int i = 0; i < 3; i++) begin
      op_a(1'b1, 1'b0, 1'b0);  // not enabled
      op_a(1'b1, 1'b1, 1'b1);  // not selected
    end
    wait_b(4);
    check("R1 unqualified fills ignored b_aempty_n", b_aempty_n, 1'b0);
    check("R1 unqualified fills ignored a_afull_n", a_afull_n, 1'b1);
  endtask

  task automatic t_far_ae;
    op_a(1'b1); n1++;
    @(negedge clk_b);
    check("R5 far fill: no change at first B edge", b_aempty_n, 1'b0);
    wait_b(2);
    check("R5 far fill: b_aempty_n up by third B edge (R2, R7)", b_aempty_n, exp_ae(n1));
  endtask

  task automatic t_fill_full;
    while (n1 < D) begin
      op_a(1'b1); n1++;
      check($sformatf("R3 R4 own fill n=%0d a_afull_n", n1), a_afull_n, exp_af(n1));
    end
    for (int i = 0; i < 4; i++) op_a(1'b1);  // R7: full, discarded
    check("R7 overfill a_afull_n", a_afull_n, 1'b0);
    wait_b(4);
    check("R2 ch1 full b_aempty_n", b_aempty_n, 1'b1);
  endtask

  task automatic t_far_af;
    op_b(1'b0); n1--;
    op_b(1'b0); n1--;
    wait_a(4);
    check("R3 n=D-Y a_afull_n", a_afull_n, exp_af(n1));
    op_b(1'b0); n1--;
    @(negedge clk_a);
    check("R5 far drain: no change at first A edge", a_afull_n, 1'b0);
    wait_a(2);
    check("R5 R8 R7 far drain raises a_afull_n by third A edge", a_afull_n, exp_af(n1));
  endtask

  task automatic t_drain;
    while (n1 > 0) begin
      op_b(1'b0); n1--;
      check($sformatf("R2 R4 own drain n=%0d b_aempty_n", n1), b_aempty_n, exp_ae(n1));
    end
    wait_a(4);
    check("R3 ch1 empty a_afull_n", a_afull_n, 1'b1);
  endtask

  task automatic t_ch2;
    op_b(1'b1); n2++;
    check("R9 R4 ch2 own fill b_afull_n", b_afull_n, exp_af(n2));
    wait_a(4);
    check("R6 offset change ignored a_aempty_n", a_aempty_n, exp_ae(n2));
    while (n2 < D) begin
      op_b(1'b1); n2++;
      check($sformatf("R9 R3 ch2 fill n=%0d b_afull_n", n2), b_afull_n, exp_af(n2));
    end
    op_b(1'b1); op_b(1'b1);  // R7: discarded
    check("R7 ch2 overfill b_afull_n", b_afull_n, 1'b0);
    wait_a(4);
    check("R9 R2 ch2 full a_aempty_n", a_aempty_n, 1'b1);
    while (n2 > 0) begin
      op_a(1'b0); n2--;
      check($sformatf("R9 R2 ch2 drain n=%0d a_aempty_n", n2), a_aempty_n, exp_ae(n2));
    end
    op_a(1'b0); op_a(1'b0);  // R7: discarded
    for (int i = 0; i < 4; i++) op_b(1'b1, 1'b1, 1'b1);  // R1: not selected
    wait_a(4);
    check("R1 R7 ch2 after ignored ops a_aempty_n", a_aempty_n, 1'b0);
    wait_b(4);
    check("R9 ch2 empty b_afull_n", b_afull_n, 1'b1);
  endtask

  initial begin
    #(8 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_empty_drain;
    t_qualify;
    t_far_ae;
    t_fill_full;
    t_far_af;
    t_drain;
    t_ch2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule